// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other through one-bit channel flags. Each processor owns a small bank of registers. The bank holds two interrupt enables, per-channel receive and transmit masks, a write-only set/clear port and a read-only status word of the flags that processor has raised. A processor posts on channel n by raising its own flag n. The peer sees that flag as an incoming message and acknowledges it by clearing it. The acknowledgement frees the channel for the sender.

Each processor gets two level interrupts. The receive interrupt fires while the peer has a flag up on a channel the processor has not masked. The transmit-free interrupt fires while an unmasked channel has its own flag down, which means the channel is free to post on. Both processors reach all registers through one word-aligned write port and a combinational read port. A read-only word reports the channel count, and another reports the revision.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After a synchronous reset, every enable, mask and flag is 0, and both interrupt outputs read 2'b00.
- R2: In a bank's control register (bank offset 0x0), bit 0 is the receive enable and bit 16 is the transmit-free enable. Only these two bits store a value and read back. All other bits read 0.
- R3: In a bank's mask register (bank offset 0x4), bits [NUM_CH-1:0] are the receive masks and bits [16+NUM_CH-1:16] are the transmit masks, where 1 masks the channel. Bits above the channel count read 0.
- R4: A write of 1 to bit 16+n of a bank's set/clear register (bank offset 0x8) raises that processor's flag n. The flag is visible in the status register (bank offset 0xC).
- R5: A write of 1 to bit n of a bank's set/clear register clears flag n in the other processor's status. Bits written as 0 change nothing.
- R6: The set/clear register always reads 0. Writes to a status register are ignored.
- R7: irq_rx[p] is high exactly when processor p's receive enable is set and the peer's flags AND NOT p's receive mask is nonzero.
- R8: irq_txfree[p] is high exactly when p's transmit-free enable is set and (NOT p's flags) AND NOT p's transmit mask is nonzero over the implemented channels.
- R9: Byte address 0x3F0 reads the channel count NUM_CH in bits 7:0. Writes there are ignored.
- R10: Byte address 0x3F4 reads the minor revision in bits 3:0 and the major revision in bits 7:4.
- R11: Processor 0's bank sits at byte address 0x00 and processor 1's at 0x10. Any other address, including unaligned ones, reads 0.
- R12: A write takes effect at the clock edge that samples it. The interrupts change only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 12 | Byte address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data at addr |
| irq_rx | output | 2 | Receive interrupt, one bit per processor |
| irq_txfree | output | 2 | Transmit-free interrupt, one bit per processor |

## Verification
Read data is a combinational function of the address and the stored state. The bench therefore samples it 1 ns after setting the address, away from any edge. Every register update and every interrupt change is due exactly one rising edge after the write strobe. The bench drives each write at a falling edge and checks results at the next falling edge. For R12, the bench also samples the interrupts while the write is still being presented, before its edge, to confirm they have not moved yet.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MAX_CH   = 16;
    localparam int NUM_PROC = 2;

    localparam logic [11:0] ADDR_CFG = 12'h3F0;
    localparam logic [11:0] ADDR_VER = 12'h3F4;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_MASK   = 2'd1,
        REG_SETCLR = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              rx_en;
        logic              tx_en;
        logic [MAX_CH-1:0] rx_mask;
        logic [MAX_CH-1:0] tx_mask;
        logic [MAX_CH-1:0] flags;
    } bank_t;

    function automatic logic [MAX_CH-1:0] chan_valid(input int n);
        logic [MAX_CH-1:0] m;
        for (int i = 0; i < MAX_CH; i++) m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic [31:0]       wdata,
    input  logic [MAX_CH-1:0] set_vec,
    input  logic [MAX_CH-1:0] clr_vec,
    output bank_t             st
);
    localparam logic [MAX_CH-1:0] VALID = chan_valid(NUM_CH);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (wr_ctrl) begin
                st.rx_en <= wdata[0];
                st.tx_en <= wdata[16];
            end
            if (wr_mask) begin
                st.rx_mask <= wdata[15:0]  & VALID;
                st.tx_mask <= wdata[31:16] & VALID;
            end
            st.flags <= (st.flags | (set_vec & VALID)) & ~clr_vec;
        end
    end

    // R4: a set request raises the addressed flags at the next edge
    p_set_raises_r4: assert property (@(posedge clk) disable iff (rst)
        ((set_vec & VALID) != '0) |=>
        ((st.flags & $past(set_vec & VALID)) == $past(set_vec & VALID)));

    // R5: a clear request from the peer drops the addressed flags
    p_clr_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0 && set_vec == '0) |=> ((st.flags & $past(clr_vec)) == '0));

    // R6: without set or clear requests the flags hold
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (set_vec == '0 && clr_vec == '0) |=> $stable(st.flags));

    // R3: bits above the channel count never store a value
    p_unused_bits_r3: assert property (@(posedge clk) disable iff (rst)
        ((st.flags | st.rx_mask | st.tx_mask) & ~VALID) == '0);

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  bank_t             own,
    input  logic [MAX_CH-1:0] peer_flags,
    output logic              irq_rx,
    output logic              irq_txfree
);
    localparam logic [MAX_CH-1:0] VALID = chan_valid(NUM_CH);

    logic [MAX_CH-1:0] rx_pending;
    logic [MAX_CH-1:0] tx_free;

    always_comb begin
        rx_pending = peer_flags & ~own.rx_mask;
        tx_free    = ~own.flags & ~own.tx_mask & VALID;
        irq_rx     = own.rx_en & (|rx_pending);
        irq_txfree = own.tx_en & (|tx_free);
    end

endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl
    import mbox_pkg::*;
#(
    parameter int         NUM_CH    = 8,
    parameter logic [3:0] VER_MAJOR = 4'd1,
    parameter logic [3:0] VER_MINOR = 4'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [1:0]  irq_rx,
    output logic [1:0]  irq_txfree
);
    localparam logic [MAX_CH-1:0] VALID = chan_valid(NUM_CH);

    bank_t             st      [NUM_PROC];
    logic              wr_ctrl [NUM_PROC];
    logic              wr_mask [NUM_PROC];
    logic [MAX_CH-1:0] set_vec [NUM_PROC];
    logic [MAX_CH-1:0] clr_vec [NUM_PROC];

    logic     bank_hit;
    logic     bank_idx;
    reg_sel_e sel;

    assign bank_hit = (addr[1:0] == 2'b00) && (addr[11:5] == '0);
    assign bank_idx = addr[4];
    assign sel      = reg_sel_e'(addr[3:2]);

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
        localparam int PEER = 1 - p;
        logic hit_own;
        logic hit_peer;

        assign hit_own  = wr_en && bank_hit && (bank_idx == 1'(p));
        assign hit_peer = wr_en && bank_hit && (bank_idx == 1'(PEER));

        always_comb begin
            wr_ctrl[p] = hit_own && (sel == REG_CTRL);
            wr_mask[p] = hit_own && (sel == REG_MASK);
            set_vec[p] = (hit_own  && sel == REG_SETCLR) ? wdata[31:16] : '0;
            clr_vec[p] = (hit_peer && sel == REG_SETCLR) ? wdata[15:0]  : '0;
        end

        mbox_bank #(.NUM_CH(NUM_CH)) i_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (wr_ctrl[p]),
            .wr_mask (wr_mask[p]),
            .wdata   (wdata),
            .set_vec (set_vec[p]),
            .clr_vec (clr_vec[p]),
            .st      (st[p])
        );

        mbox_irq #(.NUM_CH(NUM_CH)) i_irq (
            .own        (st[p]),
            .peer_flags (st[PEER].flags),
            .irq_rx     (irq_rx[p]),
            .irq_txfree (irq_txfree[p])
        );

        // R7: a receive interrupt needs a peer flag up
        p_rx_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
            irq_rx[p] |-> (st[PEER].flags != '0));

        // R8: a transmit-free interrupt needs an own flag down
        p_txfree_needs_gap_r8: assert property (@(posedge clk) disable iff (rst)
            irq_txfree[p] |-> ((st[p].flags & VALID) != VALID));
    end

    always_comb begin
        rdata = '0;
        if (bank_hit) begin
            unique case (sel)
                REG_CTRL:   rdata = {15'd0, st[bank_idx].tx_en, 15'd0, st[bank_idx].rx_en};
                REG_MASK:   rdata = {st[bank_idx].tx_mask, st[bank_idx].rx_mask};
                REG_SETCLR: rdata = '0;
                REG_STATUS: rdata = {16'd0, st[bank_idx].flags};
            endcase
        end else if (addr == ADDR_CFG) begin
            rdata = 32'(NUM_CH);
        end else if (addr == ADDR_VER) begin
            rdata = {24'd0, VER_MAJOR, VER_MINOR};
        end
    end

    // R6: the set/clear register reads back as zero
    p_setclr_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bank_hit && sel == REG_SETCLR) |-> (rdata == '0));

    // R12: interrupts move only at an edge that sampled a write
    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(irq_rx) && $stable(irq_txfree)));

endmodule

// File: tb/test_mbox_flag_ctrl.sv
`timescale 1ns/1ps
module test_mbox_flag_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq_rx;
    logic [1:0]  irq_txfree;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbox_flag_ctrl i_mbox_flag_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_rx(irq_rx), .irq_txfree(irq_txfree)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] rexp;
        logic [1:0]  xrx;
        logic [1:0]  xtx;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{12'h000, 32'hFFFF_FFFF, 12'h000, 32'h0001_0001, 2'b00, 2'b01, 8'd2},  // R2
        '{12'h004, 32'hFFFF_FFFF, 12'h004, 32'h00FF_00FF, 2'b00, 2'b00, 8'd3},  // R3
        '{12'h004, 32'h0000_0000, 12'h004, 32'h0000_0000, 2'b00, 2'b01, 8'd3},  // R3
        '{12'h010, 32'h0001_0001, 12'h010, 32'h0001_0001, 2'b00, 2'b11, 8'd11}, // R11
        '{12'h018, 32'h0005_0000, 12'h01C, 32'h0000_0005, 2'b01, 2'b11, 8'd4},  // R4 R7
        '{12'h008, 32'h0000_0001, 12'h01C, 32'h0000_0004, 2'b01, 2'b11, 8'd5},  // R5
        '{12'h004, 32'h0000_0004, 12'h004, 32'h0000_0004, 2'b00, 2'b11, 8'd7},  // R7
        '{12'h008, 32'h0000_0000, 12'h01C, 32'h0000_0004, 2'b00, 2'b11, 8'd5},  // R5
        '{12'h008, 32'h00FF_0000, 12'h00C, 32'h0000_00FF, 2'b10, 2'b10, 8'd8},  // R4 R8
        '{12'h00C, 32'h0000_0000, 12'h00C, 32'h0000_00FF, 2'b10, 2'b10, 8'd6},  // R6
        '{12'h018, 32'h0000_0080, 12'h00C, 32'h0000_007F, 2'b10, 2'b11, 8'd5},  // R5 R8
        '{12'h004, 32'h0080_0004, 12'h004, 32'h0080_0004, 2'b10, 2'b10, 8'd8},  // R8
        '{12'h3F0, 32'h0000_FFFF, 12'h3F0, 32'h0000_0008, 2'b10, 2'b10, 8'd9},  // R9
        '{12'h008, 32'h0000_0000, 12'h008, 32'h0000_0000, 2'b10, 2'b10, 8'd6}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [11:0] a);
        addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state of every bank register and the interrupts
        check("R1 irq_rx", {30'd0, irq_rx}, 32'd0);
        check("R1 irq_txfree", {30'd0, irq_txfree}, 32'd0);
        foreach (VEC[i]) begin end
        for (int a = 0; a < 32; a += 4) begin
            read_at(12'(a));
            check($sformatf("R1 reg %h", a), rdata, 32'd0);
        end
        // R10: revision word
        read_at(12'h3F4);
        check("R10 version", rdata, 32'h0000_0012);
        // R11: unmapped and unaligned reads
        read_at(12'h100);
        check("R11 unmapped", rdata, 32'd0);
        read_at(12'h3F1);
        check("R11 unaligned", rdata, 32'd0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i].wa, VEC[i].wd);
            read_at(VEC[i].ra);
            check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), rdata, VEC[i].rexp);
            check($sformatf("R%0d vec%0d irq_rx", VEC[i].req, i), {30'd0, irq_rx}, {30'd0, VEC[i].xrx});
            check($sformatf("R%0d vec%0d irq_txfree", VEC[i].req, i), {30'd0, irq_txfree}, {30'd0, VEC[i].xtx});
        end

        // R12: disabling processor 1 takes effect only after the edge
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h010; wdata = 32'd0;
        #1;
        check("R12 irq_rx before edge", {30'd0, irq_rx}, 32'd2);
        check("R12 irq_txfree before edge", {30'd0, irq_txfree}, 32'd2);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R12 irq_rx after edge", {30'd0, irq_rx}, 32'd0);
        check("R12 irq_txfree after edge", {30'd0, irq_txfree}, 32'd0);

        // R1: reset in mid-run clears flags and masks
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_at(12'h00C);
        check("R1 flags after reset", rdata, 32'd0);
        read_at(12'h004);
        check("R1 mask after reset", rdata, 32'd0);
        read_at(12'h000);
        check("R1 ctrl after reset", rdata, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule